// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block is the host side of an Enhanced Parallel Port link. A local bus master asks for one byte transfer at a time: write or read, tagged as an address cycle or a data cycle. The engine then runs the whole handshake on the port lines as a single transaction. While the handshake runs, `busy` stays high and the requester waits. A one-cycle `done` pulse marks the end, and on a read the byte is on `rd_data` at that point. Address cycles strobe the select-in line and data cycles strobe the auto-feed line. The unused strobe always stays high.

The peripheral paces each transfer with its wait line. If the wait line does not respond within `tmo_limit` clocks, the engine drops the strobe, ends the transfer and sets a sticky timeout flag. Three vendor status lines are synchronized and shown on `status`, so that flow control can be handled above this block. A falling edge on the acknowledge line sets a sticky interrupt flag. This edge does not affect a transfer that is in progress. Both flags are cleared by pulsing their clear inputs (write-1-to-clear).

Top module: `epp_host`

## Requirements
- R1: During an address cycle only `n_addr_strb` goes low; during a data cycle only `n_data_strb` goes low. The two strobes are never low together.
- R2: On a write, the cycle after acceptance has `n_write` low, `pd_oe` high and the byte on `pd_o`, with both strobes still high. The strobe falls one cycle later. Byte and direction stay put until the transfer ends.
- R3: On a read, `n_write` stays high and `pd_oe` low. The input byte is captured when the synchronized wait line is seen high. That byte is on `rd_data` when `done` pulses and is held afterwards.
- R4: After reset, `busy`, `done` and both flags are 0. `busy` is 1 from the cycle after a request is accepted until `done`. `done` is a one-cycle pulse with `busy` already 0. Requests made while `busy` is 1 are ignored.
- R5: The strobe rises exactly three clocks after `n_wait` goes high (two synchronizer stages and one sequencing step). `done` follows exactly three clocks after `n_wait` then goes low.
- R6: If `n_wait` stays low, the strobe is low for exactly `tmo_limit` clocks and then rises, with `done` and `tmo_flag` set in the same cycle. `tmo_flag` holds until `tmo_clr` is pulsed. A new timeout in the clearing cycle wins.
- R7: `status` = {perror, n_fault, sel_in} (bit 2 to bit 0), delayed by the two synchronizer stages, so a change is visible two clocks later.
- R8: A high-to-low transition on `n_ack` sets `irq_flag` on the third clock edge after it occurs. `irq_flag` holds until `irq_clr` is pulsed. An edge landing in the clearing cycle keeps the flag set.
- R9: An `n_ack` edge during a transfer does not change that transfer's strobe timing, data or completion.
- R10: `pd_oe` is 0 and `n_write` is 1 whenever no write transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| req_valid | input | 1 | request a transfer (taken when busy is 0) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| req_wdata | input | 8 | byte to write |
| tmo_limit | input | TMO_W | wait-phase timeout in clocks |
| busy | output | 1 | transfer in progress |
| done | output | 1 | one-cycle end-of-transfer pulse |
| rd_data | output | 8 | last byte read |
| tmo_flag | output | 1 | sticky timeout flag |
| tmo_clr | input | 1 | clear timeout flag (write 1) |
| irq_flag | output | 1 | sticky peripheral interrupt flag |
| irq_clr | input | 1 | clear interrupt flag (write 1) |
| status | output | 3 | synchronized {perror, n_fault, sel_in} |
| pd_o | output | 8 | port data out |
| pd_oe | output | 1 | port data output enable |
| pd_i | input | 8 | port data in |
| n_write | output | 1 | direction line, low for writes |
| n_data_strb | output | 1 | data strobe (auto-feed line), active low |
| n_addr_strb | output | 1 | address strobe (select-in line), active low |
| n_wait | input | 1 | peripheral handshake line |
| n_ack | input | 1 | peripheral interrupt line |
| perror | input | 1 | vendor status line |
| n_fault | input | 1 | vendor status line |
| sel_in | input | 1 | vendor status line |

## Verification
Each result has a fixed distance in clocks from the stimulus that causes it:
- `busy` and the write set-up appear one clock after a request.
- The strobe falls one clock after that.
- The strobe rises, or `done` pulses, three clocks after the matching `n_wait` change.
- A timeout strobe is low for exactly `tmo_limit` clocks.
- `status` lags its inputs by two clocks.
- `irq_flag` lags an `n_ack` fall by three clocks.

The bench drives inputs on the falling clock edge and then samples at exactly those later falling edges. It also checks that the strobe level is still unchanged one clock earlier. A queue-based model of the status and interrupt paths is compared on every clock, including the cycle where a clear and a new edge meet.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STRB, PH_HOLD} epp_phase_t;

  // returns {n_addr_strb, n_data_strb}
  function automatic logic [1:0] strobe_lines(input logic on, input logic addr_cyc);
    return {~(on & addr_cyc), ~(on & ~addr_cyc)};
  endfunction
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1, stg2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= RST_VAL;
      stg2 <= RST_VAL;
    end else begin
      stg1 <= d;
      stg2 <= stg1;
    end
  end
  assign q = stg2;
endmodule

// File: rtl/epp_edge_flag.sv
module epp_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic fall,
  output logic flag
);
  logic lvl_d;
  assign fall = lvl_d & ~lvl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= 1'b1;
      flag  <= 1'b0;
    end else begin
      lvl_d <= lvl;
      flag  <= fall | (flag & ~clr);
    end
  end
endmodule

// File: rtl/epp_cycle.sv
module epp_cycle
  import epp_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             tmo_clr,
  input  logic             wait_hi,
  input  logic [DW-1:0]    rdat_s,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic             tmo_flag,
  output logic             tmo_evt,
  output logic [DW-1:0]    pd_o,
  output logic             pd_oe,
  output logic             n_write,
  output logic             n_data_strb,
  output logic             n_addr_strb
);
  epp_phase_t       phase;
  logic [TMO_W-1:0] cnt;
  logic             cur_wr, cur_ad;
  logic [DW-1:0]    dout;
  logic             expired, drive;

  function automatic logic wait_over(input logic [TMO_W-1:0] c,
                                     input logic [TMO_W-1:0] lim);
    return (c + TMO_W'(1)) >= lim;
  endfunction

  assign expired = wait_over(cnt, tmo_limit);
  assign tmo_evt = expired & (((phase == PH_STRB) & ~wait_hi) |
                              ((phase == PH_HOLD) &  wait_hi));
  assign busy    = (phase != PH_IDLE);
  assign drive   = busy & cur_wr;
  assign pd_oe   = drive;
  assign n_write = ~drive;
  assign pd_o    = dout;
  assign {n_addr_strb, n_data_strb} = strobe_lines(phase == PH_STRB, cur_ad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      cur_wr   <= 1'b0;
      cur_ad   <= 1'b0;
      dout     <= '0;
      rd_data  <= '0;
      done     <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      done     <= 1'b0;
      tmo_flag <= tmo_evt | (tmo_flag & ~tmo_clr);
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          cur_wr <= req_write;
          cur_ad <= req_addr;
          dout   <= req_wdata;
          cnt    <= '0;
          phase  <= PH_SETUP;
        end
        PH_SETUP: begin
          cnt   <= '0;
          phase <= PH_STRB;
        end
        PH_STRB: begin
          if (wait_hi) begin
            if (!cur_wr) rd_data <= rdat_s;
            cnt   <= '0;
            phase <= PH_HOLD;
          end else if (expired) begin
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt + TMO_W'(1);
          end
        end
        PH_HOLD: begin
          if (!wait_hi || expired) begin
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt + TMO_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_host.sv
module epp_host #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_addr,
  input  logic [7:0]       req_wdata,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             tmo_flag,
  input  logic             tmo_clr,
  output logic             irq_flag,
  input  logic             irq_clr,
  output logic [2:0]       status,
  output logic [7:0]       pd_o,
  output logic             pd_oe,
  input  logic [7:0]       pd_i,
  output logic             n_write,
  output logic             n_data_strb,
  output logic             n_addr_strb,
  input  logic             n_wait,
  input  logic             n_ack,
  input  logic             perror,
  input  logic             n_fault,
  input  logic             sel_in
);
  localparam int DW = 8;
  localparam int SW = 3;

  logic          wait_hi;
  logic          ack_s;
  logic          ack_fall;
  logic          tmo_evt;
  logic [DW-1:0] rdat_s;

  epp_sync #(.W(1), .RST_VAL(1'b0)) i_wait_sync (
    .clk(clk), .rst_n(rst_n), .d(n_wait), .q(wait_hi));
  epp_sync #(.W(1), .RST_VAL(1'b1)) i_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(n_ack), .q(ack_s));
  epp_sync #(.W(SW), .RST_VAL('0)) i_stat_sync (
    .clk(clk), .rst_n(rst_n), .d({perror, n_fault, sel_in}), .q(status));
  epp_sync #(.W(DW), .RST_VAL('0)) i_data_sync (
    .clk(clk), .rst_n(rst_n), .d(pd_i), .q(rdat_s));

  epp_edge_flag i_irq (
    .clk(clk), .rst_n(rst_n), .lvl(ack_s), .clr(irq_clr),
    .fall(ack_fall), .flag(irq_flag));

  epp_cycle #(.TMO_W(TMO_W), .DW(DW)) i_cycle (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .tmo_limit(tmo_limit), .tmo_clr(tmo_clr),
    .wait_hi(wait_hi), .rdat_s(rdat_s),
    .busy(busy), .done(done), .rd_data(rd_data),
    .tmo_flag(tmo_flag), .tmo_evt(tmo_evt),
    .pd_o(pd_o), .pd_oe(pd_oe), .n_write(n_write),
    .n_data_strb(n_data_strb), .n_addr_strb(n_addr_strb));
endmodule

// File: rtl/epp_host_chk.sv
module epp_host_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic pd_oe,
  input logic n_write,
  input logic n_data_strb,
  input logic n_addr_strb,
  input logic wait_hi,
  input logic ack_fall,
  input logic tmo_flag,
  input logic tmo_clr,
  input logic irq_flag,
  input logic irq_clr
);
  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_data_strb || n_addr_strb);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pd_oe && n_write && n_data_strb && n_addr_strb));
  // R3
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_oe |-> !n_write);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(n_data_strb) || $rose(n_addr_strb)) |-> ($past(wait_hi) || tmo_flag));
  // R6
  tmo_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> (done && n_data_strb && n_addr_strb));
  // R6
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clr) |=> tmo_flag);
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(ack_fall));
endmodule

bind epp_host epp_host_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pd_oe(pd_oe),
  .n_write(n_write), .n_data_strb(n_data_strb), .n_addr_strb(n_addr_strb),
  .wait_hi(wait_hi), .ack_fall(ack_fall), .tmo_flag(tmo_flag),
  .tmo_clr(tmo_clr), .irq_flag(irq_flag), .irq_clr(irq_clr));

// File: tb/test_epp_host.sv
module test_epp_host;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_addr = 0;
  logic [7:0] req_wdata = '0;
  logic [15:0] tmo_limit = 16'd40;
  logic tmo_clr = 0, irq_clr = 0;
  logic [7:0] pd_i = '0;
  logic n_wait = 0, n_ack = 1, perror = 0, n_fault = 0, sel_in = 0;
  logic busy, done, tmo_flag, irq_flag, pd_oe, n_write, n_data_strb, n_addr_strb;
  logic [7:0] rd_data, pd_o;
  logic [2:0] status;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  epp_host i_epp_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .tmo_limit(tmo_limit),
    .busy(busy), .done(done), .rd_data(rd_data), .tmo_flag(tmo_flag),
    .tmo_clr(tmo_clr), .irq_flag(irq_flag), .irq_clr(irq_clr),
    .status(status), .pd_o(pd_o), .pd_oe(pd_oe), .pd_i(pd_i),
    .n_write(n_write), .n_data_strb(n_data_strb), .n_addr_strb(n_addr_strb),
    .n_wait(n_wait), .n_ack(n_ack), .perror(perror), .n_fault(n_fault),
    .sel_in(sel_in));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // behavioural model of synchronized status and interrupt flag
  bit ack_q[$];
  logic [2:0] st_q[$];
  bit m_irq;
  always @(posedge clk) begin
    if (!rst_n) begin
      ack_q = {1'b1, 1'b1, 1'b1, 1'b1};
      st_q  = {3'b000, 3'b000};
      m_irq = 0;
    end else begin
      ack_q.push_front(n_ack);
      st_q.push_front({perror, n_fault, sel_in});
      m_irq = (ack_q[3] && !ack_q[2]) || (m_irq && !irq_clr);
      void'(ack_q.pop_back());
      void'(st_q.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8 irq flag vs model", irq_flag, m_irq);
      chk("R7 status vs model", status, st_q[1]);
      if (!busy) chk("R10 output enable idle", pd_oe, 0);
      chk("R1 strobes never both low", n_data_strb | n_addr_strb, 1);
    end
  end

  task automatic xfer(input bit wr, input bit ad, input logic [7:0] d,
                      input int dly, input bit resp, input bit irq, input bit poke);
    int lowc;
    logic [1:0] act_strb;
    act_strb = ad ? 2'b01 : 2'b10;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = ad; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk("R4 busy after accept", busy, 1);
    chk(wr ? "R2 nWrite at setup" : "R3 nWrite at setup", n_write, !wr);
    chk("R2 strobes idle at setup", {n_addr_strb, n_data_strb}, 2'b11);
    if (wr) begin
      chk("R2 oe at setup", pd_oe, 1);
      chk("R2 byte at setup", pd_o, d);
    end else chk("R10 oe on read", pd_oe, 0);
    @(negedge clk);
    chk("R1 strobe choice", {n_addr_strb, n_data_strb}, act_strb);
    if (wr) chk("R2 byte under strobe", pd_o, d);
    else pd_i = d;
    if (irq) n_ack = 0;
    if (poke) begin req_valid = 1; req_wdata = ~d; req_write = !wr; end
    if (!resp) begin
      lowc = 1;
      while (lowc < 1000) begin
        @(negedge clk);
        if ({n_addr_strb, n_data_strb} == act_strb) lowc++; else break;
      end
      chk("R6 strobe low cycles", lowc, tmo_limit);
      chk("R6 timeout flag", tmo_flag, 1);
      chk("R6 done on timeout", done, 1);
    end else begin
      repeat (dly) begin
        @(negedge clk);
        req_valid = 0;
      end
      chk("R5 strobe held before wait", {n_addr_strb, n_data_strb}, act_strb);
      n_wait = 1;
      repeat (2) begin
        @(negedge clk);
        req_valid = 0;
        chk("R5 strobe held through sync", {n_addr_strb, n_data_strb}, act_strb);
      end
      @(negedge clk);
      chk("R5 strobe released", {n_addr_strb, n_data_strb}, 2'b11);
      n_wait = 0;
      repeat (2) begin
        @(negedge clk);
        chk("R5 not done before wait low", done, 0);
        chk("R2 busy held", busy, 1);
        if (wr) chk("R2 nWrite held", n_write, 0);
      end
      @(negedge clk);
      chk("R5 done pulse", done, 1);
      chk("R4 idle at done", busy, 0);
      chk("R10 nWrite released", n_write, 1);
      if (!wr) chk("R3 read byte", rd_data, d);
      @(negedge clk);
      chk("R4 done one cycle", done, 0);
      if (!wr) chk("R3 read byte held", rd_data, d);
      if (poke) repeat (3) begin
        @(negedge clk);
        chk("R4 ignored request", busy, 0);
      end
      if (irq) chk("R9 irq captured, transfer intact", irq_flag, 1);
    end
    if (irq) n_ack = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    wrap_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset busy", busy, 0);
    chk("R4 reset done", done, 0);
    chk("R6 reset tmo", tmo_flag, 0);
    chk("R8 reset irq", irq_flag, 0);
    chk("R10 reset nWrite", n_write, 1);
    chk("R1 reset strobes", {n_addr_strb, n_data_strb}, 2'b11);

    xfer(1, 0, 8'hA5, 2, 1, 0, 0);
    xfer(1, 1, 8'h3C, 0, 1, 0, 0);
    xfer(0, 0, 8'h5A, 4, 1, 0, 0);
    xfer(0, 1, 8'hC3, 1, 1, 0, 1);
    xfer(1, 0, 8'h77, 6, 1, 1, 0);
    xfer(0, 0, 8'h96, 3, 1, 1, 0);

    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk("R8 irq cleared", irq_flag, 0);

    // status lines
    {perror, n_fault, sel_in} = 3'b101;
    @(negedge clk);
    chk("R7 status not yet", status, 3'b000);
    @(negedge clk);
    chk("R7 status after two clocks", status, 3'b101);
    {perror, n_fault, sel_in} = 3'b010;
    repeat (3) @(negedge clk);
    chk("R7 status second pattern", status, 3'b010);

    // timeout
    tmo_limit = 16'd5;
    xfer(1, 1, 8'h11, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R6 timeout sticky", tmo_flag, 1);
    tmo_clr = 1;
    @(negedge clk); tmo_clr = 0;
    chk("R6 timeout cleared", tmo_flag, 0);
    tmo_limit = 16'd9;
    xfer(0, 0, 8'h22, 0, 0, 0, 0);
    tmo_clr = 1;
    @(negedge clk); tmo_clr = 0;
    tmo_limit = 16'd40;

    // edge meets clear
    n_ack = 0;
    repeat (4) @(negedge clk);
    chk("R8 flag set by edge", irq_flag, 1);
    n_ack = 1;
    repeat (3) @(negedge clk);
    n_ack = 0;
    repeat (2) @(negedge clk);
    irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk("R8 edge wins over clear", irq_flag, 1);
    n_ack = 1;
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk("R8 cleared after collision", irq_flag, 0);

    xfer(1, 1, 8'hE1, 1, 1, 0, 0);
    repeat (4) @(negedge clk);
    wrap_up();
  end
endmodule